// File: doc/BRIEF.md
# Segmented Dual-Clock Simple Dual-Port RAM

This block is a buffer RAM placed between a DMA interface engine and a DMA client. One side only writes and the other side only reads. Each side has its own clock, so the engine and the client may run in unrelated clock domains without a datapath FIFO. Both sides are cut into several segments. Each segment has its own command channel and its own row address. A transfer that is not aligned to a row can therefore write row r in one segment and row r+1 in another segment in the same cycle.

Each write segment carries a byte-enable mask. Each read segment returns data over a valid/ready channel, through a chain of output registers whose length is set by a parameter. The row count of the storage is set apart from the address width. Address bits that select rows beyond the storage are dropped. Each reset input is asserted asynchronously and released in step with its own clock.

Top module: `seg_dpram`

## Requirements
- R1: Data written through the write port, clocked by `wr_clk`, can be read back through the read port, clocked by the unrelated `rd_clk`.
- R2: A write replaces only the bytes whose enable bit is set. Bit b of a segment's enable field guards bits [8b+7:8b] of that segment's data. All other bytes of the row keep their old value.
- R3: Segment k owns bits [k*SEG_DW +: SEG_DW] of the data buses, bits [k*AW +: AW] of the address buses and bit k of the valid and ready vectors. Segments accept different row addresses in the same cycle and do not affect one another.
- R4: Only the low log2(DEPTH) address bits select a row. An address with higher bits set reaches the same row as the address with those bits cleared.
- R5: When the output is not stalled, a read command presented before rd_clk edge E and accepted at E shows its data with `rd_resp_valid` high just after edge E+PIPE. That is PIPE+1 clock cycles after the command is presented.
- R6: While a segment's `rd_resp_valid` is high and its `rd_resp_ready` is low, its `rd_resp_data` and `rd_resp_valid` stay unchanged. No read result is lost, duplicated or reordered under backpressure.
- R7: While a port's reset is asserted, its command ready outputs are low and `rd_resp_valid` is low. Within two cycles of reset release, every command ready output is high.
- R8: A read segment holds at most PIPE+1 results. With its output stalled and PIPE+1 results held, its `rd_cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst_n | input | 1 | Write side reset, active low |
| wr_cmd_valid | input | SEGS | Per-segment write command valid |
| wr_cmd_ready | output | SEGS | Per-segment write command ready |
| wr_cmd_addr | input | SEGS*AW | Per-segment write row address |
| wr_cmd_be | input | SEGS*SEG_DW/8 | Per-segment byte enables |
| wr_cmd_data | input | SEGS*SEG_DW | Per-segment write data |
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Read side reset, active low |
| rd_cmd_valid | input | SEGS | Per-segment read command valid |
| rd_cmd_ready | output | SEGS | Per-segment read command ready |
| rd_cmd_addr | input | SEGS*AW | Per-segment read row address |
| rd_resp_valid | output | SEGS | Per-segment read data valid |
| rd_resp_ready | input | SEGS | Per-segment read data ready |
| rd_resp_data | output | SEGS*SEG_DW | Per-segment read data |

## Verification
The case that matters most on the read side is a result leaving the last output register in the same cycle that a new command enters the RAM stage. This happens while older results are still moving between stages. The bench provokes it by issuing reads back to back while each segment's `rd_resp_ready` toggles in its own pattern: every second cycle on one segment, two cycles out of three on the other. A scoreboard queue per segment, filled from a reference memory model when each command is issued, must then match every handshaken result in order. The response data must also stay the same through every stalled cycle.

// File: rtl/seg_dpram_pkg.sv
`timescale 1ns/1ps
package seg_dpram_pkg;
  // width of one byte lane guarded by one enable bit
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/seg_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release
module seg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/seg_ram_bank.sv
`timescale 1ns/1ps
// One segment of storage: byte-masked write on wr_clk, registered read on rd_clk
module seg_ram_bank
  import seg_dpram_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned DEPTH = 64
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW/LANE_W-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned LANES = DW / LANE_W;
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] ridx;

  // upper address bits beyond the storage are dropped
  assign widx = waddr[IDX_W-1:0];
  assign ridx = raddr[IDX_W-1:0];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (wbe[b]) mem[widx][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/seg_rd_pipe.sv
`timescale 1ns/1ps
// Valid/ready control for the RAM read stage plus PIPE output registers
module seg_rd_pipe #(
  parameter int unsigned DW   = 32,
  parameter int unsigned PIPE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  output logic          ram_re,
  input  logic [DW-1:0] ram_q,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data
);
  localparam int unsigned STG = PIPE + 1;
  localparam int unsigned CW  = $clog2(STG + 1) + 1;

  logic [STG-1:0] vld_q, vld_d, adv, load;
  logic           fire;

  // stage s advances when it holds data and the stage after it can take it
  always_comb begin
    logic room;
    room = resp_ready;
    for (int s = STG - 1; s >= 0; s--) begin
      adv[s] = vld_q[s] & room;
      room   = ~vld_q[s] | adv[s];
    end
    cmd_ready = room & rst_n;
  end

  assign fire   = cmd_valid & cmd_ready;
  assign ram_re = fire;

  always_comb begin
    for (int s = 0; s < STG; s++) begin
      load[s]  = (s == 0) ? fire : adv[(s == 0) ? 0 : s - 1];
      vld_d[s] = load[s] | (vld_q[s] & ~adv[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign resp_valid = vld_q[STG-1];

  generate
    if (PIPE == 0) begin : g_no_pipe
      assign resp_data = ram_q;
    end else begin : g_pipe
      logic [PIPE*DW-1:0]     dat_q;
      logic [(PIPE+1)*DW-1:0] chain;
      assign chain = {dat_q, ram_q};
      always_ff @(posedge clk) begin
        for (int s = 1; s <= PIPE; s++) begin
          if (load[s]) dat_q[(s-1)*DW +: DW] <= chain[(s-1)*DW +: DW];
        end
      end
      assign resp_data = chain[PIPE*DW +: DW];
    end
  endgenerate

  // occupancy tracker used only by the checks below
  logic [CW-1:0] occ_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + CW'(fire) - CW'(resp_valid & resp_ready);
  end

  a_r5_enter_ram_stage: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> vld_q[0]);
  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));
  a_r6_drop_only_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resp_valid) |-> $past(resp_ready));
  a_r8_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(STG));
endmodule

// File: rtl/seg_dpram.sv
`timescale 1ns/1ps
module seg_dpram
  import seg_dpram_pkg::*;
#(
  parameter int unsigned SEGS   = 2,
  parameter int unsigned SEG_DW = 32,
  parameter int unsigned AW     = 10,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PIPE   = 2
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst_n,
  input  logic [SEGS-1:0]          wr_cmd_valid,
  output logic [SEGS-1:0]          wr_cmd_ready,
  input  logic [SEGS*AW-1:0]       wr_cmd_addr,
  input  logic [SEGS*SEG_DW/8-1:0] wr_cmd_be,
  input  logic [SEGS*SEG_DW-1:0]   wr_cmd_data,
  input  logic                     rd_clk,
  input  logic                     rd_rst_n,
  input  logic [SEGS-1:0]          rd_cmd_valid,
  output logic [SEGS-1:0]          rd_cmd_ready,
  input  logic [SEGS*AW-1:0]       rd_cmd_addr,
  output logic [SEGS-1:0]          rd_resp_valid,
  input  logic [SEGS-1:0]          rd_resp_ready,
  output logic [SEGS*SEG_DW-1:0]   rd_resp_data
);
  localparam int unsigned BEW = SEG_DW / LANE_W;

  logic wr_live_n;
  logic rd_live_n;

  seg_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_live_n));
  seg_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_live_n));

  generate
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
      logic              we;
      logic              re;
      logic [SEG_DW-1:0] q;

      assign wr_cmd_ready[k] = wr_live_n;
      assign we = wr_cmd_valid[k] & wr_live_n;

      seg_ram_bank #(.DW(SEG_DW), .AW(AW), .DEPTH(DEPTH)) u_bank (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (wr_cmd_addr[k*AW +: AW]),
        .wbe    (wr_cmd_be[k*BEW +: BEW]),
        .wdata  (wr_cmd_data[k*SEG_DW +: SEG_DW]),
        .rd_clk (rd_clk),
        .re     (re),
        .raddr  (rd_cmd_addr[k*AW +: AW]),
        .rdata  (q)
      );

      seg_rd_pipe #(.DW(SEG_DW), .PIPE(PIPE)) u_pipe (
        .clk        (rd_clk),
        .rst_n      (rd_live_n),
        .cmd_valid  (rd_cmd_valid[k]),
        .cmd_ready  (rd_cmd_ready[k]),
        .ram_re     (re),
        .ram_q      (q),
        .resp_valid (rd_resp_valid[k]),
        .resp_ready (rd_resp_ready[k]),
        .resp_data  (rd_resp_data[k*SEG_DW +: SEG_DW])
      );
    end
  endgenerate
endmodule

// File: tb/tb_seg_dpram.sv
`timescale 1ns/1ps
module tb_seg_dpram;
  localparam int SEGS = 2, SEG_DW = 32, AW = 10, DEPTH = 64, PIPE = 2;
  localparam int BEW = SEG_DW / 8;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n, rd_rst_n;
  logic [SEGS-1:0] wr_cmd_valid, wr_cmd_ready, rd_cmd_valid, rd_cmd_ready;
  logic [SEGS-1:0] rd_resp_valid, rd_resp_ready;
  logic [SEGS*AW-1:0] wr_cmd_addr, rd_cmd_addr;
  logic [SEGS*BEW-1:0] wr_cmd_be;
  logic [SEGS*SEG_DW-1:0] wr_cmd_data, rd_resp_data;

  always #5 wr_clk = ~wr_clk;   // 100 MHz
  always #7 rd_clk = ~rd_clk;   // unrelated read clock

  seg_dpram #(.SEGS(SEGS), .SEG_DW(SEG_DW), .AW(AW), .DEPTH(DEPTH), .PIPE(PIPE)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_cmd_valid(wr_cmd_valid),
    .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr), .wr_cmd_be(wr_cmd_be),
    .wr_cmd_data(wr_cmd_data), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_data(rd_resp_data));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [SEG_DW-1:0] model [SEGS][DEPTH];
  logic [SEG_DW-1:0] expq [SEGS][$];
  logic [SEG_DW-1:0] held [SEGS];
  bit hold_seen [SEGS];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [SEGS-1:0] m, input logic [SEGS*AW-1:0] a,
                        input logic [SEGS*BEW-1:0] be, input logic [SEGS*SEG_DW-1:0] d);
    @(posedge wr_clk); #1;
    wr_cmd_valid = m; wr_cmd_addr = a; wr_cmd_be = be; wr_cmd_data = d;
    for (int k = 0; k < SEGS; k++) begin
      if (m[k]) begin
        for (int b = 0; b < BEW; b++) begin
          if (be[k*BEW + b]) model[k][a[k*AW +: AW] % DEPTH][b*8 +: 8] = d[k*SEG_DW + b*8 +: 8];
        end
      end
    end
    @(posedge wr_clk); #1;
    wr_cmd_valid = '0;
  endtask

  // driver: push expected data at issue time, hold valid until each segment accepts
  task automatic rd_issue(input logic [SEGS-1:0] m, input logic [SEGS*AW-1:0] a);
    logic [SEGS-1:0] pend, acc;
    @(posedge rd_clk); #1;
    rd_cmd_valid = m; rd_cmd_addr = a;
    for (int k = 0; k < SEGS; k++)
      if (m[k]) expq[k].push_back(model[k][a[k*AW +: AW] % DEPTH]);
    pend = m;
    while (pend != '0) begin
      @(negedge rd_clk);
      acc = pend & rd_cmd_ready;
      @(posedge rd_clk); #1;
      pend = pend & ~acc;
      rd_cmd_valid = pend;
    end
  endtask

  // monitor: compares handshaken results and checks stability while stalled
  always @(negedge rd_clk) begin
    if (!done && rd_rst_n) begin
      for (int k = 0; k < SEGS; k++) begin
        if (rd_resp_valid[k] && hold_seen[k])
          check(rd_resp_data[k*SEG_DW +: SEG_DW] == held[k], "R6 stalled data stable",
                rd_resp_data[k*SEG_DW +: SEG_DW], held[k]);
        if (hold_seen[k] && !rd_resp_valid[k])
          check(0, "R6 valid dropped while stalled", 0, 1);
        if (rd_resp_valid[k] && rd_resp_ready[k]) begin
          if (expq[k].size() == 0) check(0, "R1 unexpected read result", rd_resp_data[k*SEG_DW +: SEG_DW], 0);
          else begin
            logic [SEG_DW-1:0] e;
            e = expq[k].pop_front();
            check(rd_resp_data[k*SEG_DW +: SEG_DW] == e, "R1/R3 read data",
                  rd_resp_data[k*SEG_DW +: SEG_DW], e);
          end
        end
        hold_seen[k] = rd_resp_valid[k] && !rd_resp_ready[k];
        held[k] = rd_resp_data[k*SEG_DW +: SEG_DW];
      end
    end
  end

  task automatic drain(input string req);
    int w = 0;
    while ((expq[0].size() != 0 || expq[1].size() != 0) && w < 300) begin
      @(posedge rd_clk); w++;
    end
    repeat (3) @(posedge rd_clk);
    check(expq[0].size() == 0 && expq[1].size() == 0, req, expq[0].size() + expq[1].size(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SEGS*AW-1:0] ra;
    int n;
    bit got, tog;
    int c;
    for (int k = 0; k < SEGS; k++) hold_seen[k] = 0;
    wr_rst_n = 0; rd_rst_n = 0;
    wr_cmd_valid = '0; wr_cmd_addr = '0; wr_cmd_be = '0; wr_cmd_data = '0;
    rd_cmd_valid = '0; rd_cmd_addr = '0; rd_resp_ready = '1;
    repeat (4) @(posedge rd_clk);
    #2;
    check(rd_resp_valid == '0, "R7 resp_valid low in reset", rd_resp_valid, 0);
    check(rd_cmd_ready == '0, "R7 rd ready low in reset", rd_cmd_ready, 0);
    check(wr_cmd_ready == '0, "R7 wr ready low in reset", wr_cmd_ready, 0);
    @(negedge wr_clk); wr_rst_n = 1;
    @(negedge rd_clk); rd_rst_n = 1;
    repeat (3) @(posedge rd_clk);
    #2;
    check(wr_cmd_ready == '1, "R7 wr ready after reset", wr_cmd_ready, 3);
    check(rd_cmd_ready == '1, "R7 rd ready after reset", rd_cmd_ready, 3);
    check(rd_resp_valid == '0, "R7 no result after reset", rd_resp_valid, 0);

    // R1 R3: both segments write different rows in the same cycle
    for (int i = 0; i < 16; i++)
      wr_cmd(2'b11, {AW'(i + 20), AW'(i)}, '1, {32'hB000_0000 + 32'(i * 3), 32'hA000_0000 + 32'(i * 7)});
    for (int i = 0; i < 16; i++) rd_issue(2'b11, {AW'(i + 20), AW'(i)});
    for (int i = 0; i < 16; i++) rd_issue(2'b11, {AW'(i), AW'(i + 20)});
    drain("R1 all results returned");

    // R2: partial byte enables
    wr_cmd(2'b11, {AW'(23), AW'(3)}, {4'b1000, 4'b0101}, {32'h1122_3344, 32'h5566_7788});
    rd_issue(2'b11, {AW'(23), AW'(3)});
    drain("R2 results returned");
    check(model[0][3] == 32'hA066_0088, "R2 model sanity seg0", model[0][3], 32'hA066_0088);

    // R4: upper address bits dropped
    wr_cmd(2'b11, {AW'(512 + 7), AW'(64 + 5)}, '1, {32'hCAFE_0007, 32'hBEEF_0005});
    rd_issue(2'b11, {AW'(7), AW'(5)});
    rd_issue(2'b11, {AW'(128 + 7), AW'(256 + 5)});
    drain("R4 alias results returned");

    // R5: latency with output free
    rd_resp_ready = '1;
    @(posedge rd_clk); #1;
    rd_cmd_valid = 2'b01; rd_cmd_addr = {AW'(0), AW'(2)};
    expq[0].push_back(model[0][2]);
    n = 0; got = 0;
    while (!got && n < 20) begin
      @(posedge rd_clk); n++;
      if (n == 1) begin #1; rd_cmd_valid = '0; end
      @(negedge rd_clk);
      if (rd_resp_valid[0]) got = 1;
    end
    check(n == PIPE + 1, "R5 read latency", n, PIPE + 1);
    drain("R5 result returned");

    // R6 R8: stall until full
    @(posedge rd_clk); #1; rd_resp_ready = '0;
    for (int i = 0; i <= PIPE; i++) rd_issue(2'b11, {AW'(i + 21), AW'(i + 1)});
    repeat (3) @(negedge rd_clk);
    check(rd_cmd_ready == '0, "R8 ready low when full", rd_cmd_ready, 0);
    check(rd_resp_valid == '1, "R6 valid held while stalled", rd_resp_valid, 3);
    @(posedge rd_clk); #1; rd_resp_ready = '1;
    drain("R6 stalled results returned");

    // R6 R3: back-to-back reads with independent per-segment backpressure
    tog = 1; c = 0;
    fork
      begin
        for (int i = 0; i < 24; i++) rd_issue(2'b11, {AW'((i * 5) % 16 + 20), AW'(i % 16)});
        tog = 0;
      end
      begin
        while (tog) begin
          @(posedge rd_clk); #1; c++;
          rd_resp_ready = {1'(c % 3 != 0), 1'(c % 2 == 0)};
        end
      end
    join
    @(posedge rd_clk); #1; rd_resp_ready = '1;
    drain("R6 no result lost under backpressure");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule